// File: doc/BRIEF.md
# Per-Port Access Fault Logger

This block sits beside a memory protection checker that guards several slave ports. Whenever the checker refuses an access on a port, it raises a one-cycle fault strobe for that port together with a description of the refused transfer. The logger keeps one record per port holding the requesting master, a two-bit attribute code, the transfer direction, a two-bit code for how the address related to the region descriptors, the full faulting address and a process identifier. It also keeps a sticky status flag for each port.

Only the first fault after a clear is kept. Later faults on a flagged port are dropped until software clears that port's flag through a write-one-to-clear strobe. A clear that coincides with a fresh fault gives way to the fault. Software reads a record through a one-cycle-latency read port that selects a port by number. Every port has its own slot, so faults on different ports in the same cycle are all recorded.

Top module: `acc_fault_log`

## Requirements
- R1: After synchronous reset every status flag is 0, `rd_valid` is 0, and a read of any port returns an all-zero record with `rd_flag` 0.
- R2: A fault strobe on a port whose flag is 0 stores master, attribute, direction, control code, address and process ID, and sets that port's flag at the next clock edge.
- R3: While a port's flag is 1 and no clear is applied, further faults on that port leave both the stored record and the flag unchanged.
- R4: A clear strobe on a port with no fault in the same cycle drops its flag at the next edge. A clear on a port whose flag is already 0 has no effect on that port's flag or its stored record.
- R5: When a clear and a fault on the same port occur in the same cycle, the new fault is stored and the flag stays 1.
- R6: Ports are independent. Simultaneous faults on several ports are all captured in that cycle, and a clear on one port leaves the other ports' flags and records unchanged.
- R7: A read strobe with `rd_sel` below `NUM_PORTS` returns that port's record and flag one cycle later, with `rd_valid` high for exactly that cycle. A select of `NUM_PORTS` or above returns an all-zero record with `rd_flag` 0.
- R8: Codes are stored verbatim. The attribute is 0 for a user instruction fetch, 1 for user data, 2 for a supervisor instruction fetch and 3 for supervisor data. The direction bit is 0 for read and 1 for write. The control code is 0 for no region hit, 1 for a single-region violation and 2 for an overlapping-region violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_valid | input | NUM_PORTS | One-cycle fault strobe per port |
| fault_master | input | NUM_PORTS*MASTER_W | Master number per port |
| fault_attr | input | NUM_PORTS*2 | Attribute code per port |
| fault_write | input | NUM_PORTS | Direction per port, 1 = write |
| fault_ctrl | input | NUM_PORTS*2 | Region relation code per port |
| fault_addr | input | NUM_PORTS*ADDR_W | Faulting address per port |
| fault_pid | input | NUM_PORTS*PID_W | Process identifier per port |
| err_clr | input | NUM_PORTS | Write-one-to-clear strobe per port |
| err_flag | output | NUM_PORTS | Sticky status flag per port |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | SEL_W | Port number to read |
| rd_valid | output | 1 | Read data valid |
| rd_flag | output | 1 | Flag of the read port |
| rd_master | output | MASTER_W | Stored master |
| rd_attr | output | 2 | Stored attribute |
| rd_write | output | 1 | Stored direction |
| rd_ctrl | output | 2 | Stored region relation code |
| rd_addr | output | ADDR_W | Stored address |
| rd_pid | output | PID_W | Stored process ID |

## Verification
A clear and a new fault can land on the same port in the same clock cycle. The bench provokes this by capturing one fault on a port and then, in a single cycle, raising both the clear strobe and a second fault with different contents on that port. The result is judged at the ports. The flag must still read 1, and a read of that port must return the second fault's fields rather than the first. A separate cycle raises faults on two ports at once, and both records are read back to confirm that neither capture was lost.

// File: rtl/acc_fault_pkg.sv
package acc_fault_pkg;
  localparam int ATTR_W = 2;
  localparam int CTRL_W = 2;

  typedef enum logic [ATTR_W-1:0] {
    ATTR_USR_INSN = 2'd0,
    ATTR_USR_DATA = 2'd1,
    ATTR_SUP_INSN = 2'd2,
    ATTR_SUP_DATA = 2'd3
  } fl_attr_e;

  typedef enum logic [CTRL_W-1:0] {
    CTL_NO_HIT  = 2'd0,
    CTL_SINGLE  = 2'd1,
    CTL_OVERLAP = 2'd2,
    CTL_RSVD    = 2'd3
  } fl_ctrl_e;
endpackage

// File: rtl/acc_fault_slot.sv
module acc_fault_slot
  import acc_fault_pkg::*;
#(
  parameter int MASTER_W = 4,
  parameter int ADDR_W   = 32,
  parameter int PID_W    = 8,
  localparam int REC_W   = MASTER_W + ATTR_W + 1 + CTRL_W + ADDR_W + PID_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hit,
  input  logic                clr,
  input  logic [MASTER_W-1:0] master,
  input  logic [ATTR_W-1:0]   attr,
  input  logic                write,
  input  logic [CTRL_W-1:0]   ctrl,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [PID_W-1:0]    pid,
  output logic                flag_o,
  output logic [REC_W-1:0]    rec_o
);
  logic                flag_q;
  logic [MASTER_W-1:0] master_q;
  fl_attr_e            attr_q;
  logic                write_q;
  fl_ctrl_e            ctrl_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [PID_W-1:0]    pid_q;
  logic                take;

  // a fault wins when the slot is free or is being freed this cycle
  always_comb take = hit && (!flag_q || clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q   <= 1'b0;
      master_q <= '0;
      attr_q   <= ATTR_USR_INSN;
      write_q  <= 1'b0;
      ctrl_q   <= CTL_NO_HIT;
      addr_q   <= '0;
      pid_q    <= '0;
    end else if (take) begin
      flag_q   <= 1'b1;
      master_q <= master;
      attr_q   <= fl_attr_e'(attr);
      write_q  <= write;
      ctrl_q   <= fl_ctrl_e'(ctrl);
      addr_q   <= addr;
      pid_q    <= pid;
    end else if (clr) begin
      flag_q   <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign rec_o  = {master_q, attr_q, write_q, ctrl_q, addr_q, pid_q};
endmodule

// File: rtl/acc_fault_rdmux.sv
module acc_fault_rdmux #(
  parameter int NUM_PORTS = 5,
  parameter int REC_W     = 49,
  parameter int SEL_W     = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PORTS*REC_W-1:0] rec_flat,
  input  logic [NUM_PORTS-1:0]       flags,
  input  logic                       rd_en,
  input  logic [SEL_W-1:0]           rd_sel,
  output logic                       rd_valid,
  output logic                       rd_flag,
  output logic [REC_W-1:0]           rd_rec
);
  logic in_range;
  always_comb in_range = int'(rd_sel) < NUM_PORTS;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_flag  <= 1'b0;
      rd_rec   <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (in_range) begin
          rd_rec  <= rec_flat[int'(rd_sel)*REC_W +: REC_W];
          rd_flag <= flags[rd_sel];
        end else begin
          rd_rec  <= '0;
          rd_flag <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/acc_fault_log.sv
module acc_fault_log
  import acc_fault_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int MASTER_W  = 4,
  parameter int ADDR_W    = 32,
  parameter int PID_W     = 8,
  localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_PORTS-1:0]          fault_valid,
  input  logic [NUM_PORTS*MASTER_W-1:0] fault_master,
  input  logic [NUM_PORTS*ATTR_W-1:0]   fault_attr,
  input  logic [NUM_PORTS-1:0]          fault_write,
  input  logic [NUM_PORTS*CTRL_W-1:0]   fault_ctrl,
  input  logic [NUM_PORTS*ADDR_W-1:0]   fault_addr,
  input  logic [NUM_PORTS*PID_W-1:0]    fault_pid,
  input  logic [NUM_PORTS-1:0]          err_clr,
  output logic [NUM_PORTS-1:0]          err_flag,
  input  logic                          rd_en,
  input  logic [SEL_W-1:0]              rd_sel,
  output logic                          rd_valid,
  output logic                          rd_flag,
  output logic [MASTER_W-1:0]           rd_master,
  output logic [ATTR_W-1:0]             rd_attr,
  output logic                          rd_write,
  output logic [CTRL_W-1:0]             rd_ctrl,
  output logic [ADDR_W-1:0]             rd_addr,
  output logic [PID_W-1:0]              rd_pid
);
  localparam int REC_W = MASTER_W + ATTR_W + 1 + CTRL_W + ADDR_W + PID_W;

  logic [NUM_PORTS*REC_W-1:0] rec_flat;
  logic [REC_W-1:0]           rd_rec;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_slot
    acc_fault_slot #(
      .MASTER_W(MASTER_W), .ADDR_W(ADDR_W), .PID_W(PID_W)
    ) u_slot (
      .clk    (clk),
      .rst    (rst),
      .hit    (fault_valid[p]),
      .clr    (err_clr[p]),
      .master (fault_master[p*MASTER_W +: MASTER_W]),
      .attr   (fault_attr[p*ATTR_W +: ATTR_W]),
      .write  (fault_write[p]),
      .ctrl   (fault_ctrl[p*CTRL_W +: CTRL_W]),
      .addr   (fault_addr[p*ADDR_W +: ADDR_W]),
      .pid    (fault_pid[p*PID_W +: PID_W]),
      .flag_o (err_flag[p]),
      .rec_o  (rec_flat[p*REC_W +: REC_W])
    );
  end

  acc_fault_rdmux #(
    .NUM_PORTS(NUM_PORTS), .REC_W(REC_W), .SEL_W(SEL_W)
  ) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rec_flat (rec_flat),
    .flags    (err_flag),
    .rd_en    (rd_en),
    .rd_sel   (rd_sel),
    .rd_valid (rd_valid),
    .rd_flag  (rd_flag),
    .rd_rec   (rd_rec)
  );

  assign {rd_master, rd_attr, rd_write, rd_ctrl, rd_addr, rd_pid} = rd_rec;
endmodule

// File: rtl/acc_fault_log_chk.sv
module acc_fault_log_chk #(
  parameter int NUM_PORTS = 5,
  parameter int REC_W     = 49
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_PORTS-1:0]       fault_valid,
  input logic [NUM_PORTS-1:0]       err_clr,
  input logic [NUM_PORTS-1:0]       err_flag,
  input logic                       rd_en,
  input logic                       rd_valid,
  input logic [NUM_PORTS*REC_W-1:0] rec_flat
);
  // R1: reset leaves every flag low and no read in flight
  a_r1_reset_clean: assert property (@(posedge clk)
    rst |=> (err_flag == '0 && !rd_valid));

  // R7: read data valid follows the read strobe by one cycle
  a_r7_read_latency: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  a_r7_no_spurious_read: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    // R2: a fault on a free slot raises its flag
    a_r2_fault_sets_flag: assert property (@(posedge clk) disable iff (rst)
      fault_valid[i] |=> err_flag[i]);
    // R3: a held record is frozen until cleared
    a_r3_hold_first: assert property (@(posedge clk) disable iff (rst)
      (err_flag[i] && !err_clr[i]) |=>
        (err_flag[i] && $stable(rec_flat[i*REC_W +: REC_W])));
    // R4: a bare clear drops the flag
    a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
      (err_clr[i] && !fault_valid[i]) |=> !err_flag[i]);
    // R5: a fault beats a coincident clear
    a_r5_fault_beats_clear: assert property (@(posedge clk) disable iff (rst)
      (err_clr[i] && fault_valid[i]) |=> err_flag[i]);
    // R6: a port's flag and record move only on that port's own strobes
    a_r6_port_isolated: assert property (@(posedge clk) disable iff (rst)
      (!err_clr[i] && !fault_valid[i]) |=>
        ($stable(err_flag[i]) && $stable(rec_flat[i*REC_W +: REC_W])));
  end
endmodule

bind acc_fault_log acc_fault_log_chk #(
  .NUM_PORTS(NUM_PORTS), .REC_W(REC_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fault_valid (fault_valid),
  .err_clr     (err_clr),
  .err_flag    (err_flag),
  .rd_en       (rd_en),
  .rd_valid    (rd_valid),
  .rec_flat    (rec_flat)
);

// File: tb/acc_fault_log_tb.sv
module acc_fault_log_tb;
  localparam int NP = 5;
  localparam int MW = 4;
  localparam int AW = 32;
  localparam int PW = 8;
  localparam int SW = 3;

  typedef struct {
    logic [MW-1:0] master;
    logic [1:0]    attr;
    logic          wr;
    logic [1:0]    ctrl;
    logic [AW-1:0] addr;
    logic [PW-1:0] pid;
    logic          flag;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NP-1:0] f_valid = '0;
  logic [NP-1:0] f_write = '0;
  logic [NP-1:0] clr     = '0;
  logic [MW-1:0] f_master [NP];
  logic [1:0]    f_attr   [NP];
  logic [1:0]    f_ctrl   [NP];
  logic [AW-1:0] f_addr   [NP];
  logic [PW-1:0] f_pid    [NP];
  logic [NP*MW-1:0] master_flat;
  logic [NP*2-1:0]  attr_flat, ctrl_flat;
  logic [NP*AW-1:0] addr_flat;
  logic [NP*PW-1:0] pid_flat;

  for (genvar p = 0; p < NP; p++) begin : g_pack
    assign master_flat[p*MW +: MW] = f_master[p];
    assign attr_flat[p*2 +: 2]     = f_attr[p];
    assign ctrl_flat[p*2 +: 2]     = f_ctrl[p];
    assign addr_flat[p*AW +: AW]   = f_addr[p];
    assign pid_flat[p*PW +: PW]    = f_pid[p];
  end

  logic          rd_en = 1'b0;
  logic [SW-1:0] rd_sel = '0;
  logic [NP-1:0] err_flag;
  logic          rd_valid, rd_flag, rd_write;
  logic [MW-1:0] rd_master;
  logic [1:0]    rd_attr, rd_ctrl;
  logic [AW-1:0] rd_addr;
  logic [PW-1:0] rd_pid;

  acc_fault_log #(.NUM_PORTS(NP), .MASTER_W(MW), .ADDR_W(AW), .PID_W(PW)) u_dut (
    .clk(clk), .rst(rst),
    .fault_valid(f_valid), .fault_master(master_flat), .fault_attr(attr_flat),
    .fault_write(f_write), .fault_ctrl(ctrl_flat), .fault_addr(addr_flat),
    .fault_pid(pid_flat), .err_clr(clr), .err_flag(err_flag),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_valid(rd_valid), .rd_flag(rd_flag),
    .rd_master(rd_master), .rd_attr(rd_attr), .rd_write(rd_write),
    .rd_ctrl(rd_ctrl), .rd_addr(rd_addr), .rd_pid(rd_pid)
  );

  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 0;
  exp_t sb_q[$];

  // monitor: pops one expected item per valid read
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      n_checks++;
      if (sb_q.size() == 0) begin
        n_errors++;
        $display("FAIL R7: unexpected rd_valid, actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (rd_master !== e.master || rd_attr !== e.attr || rd_write !== e.wr ||
            rd_ctrl !== e.ctrl || rd_addr !== e.addr || rd_pid !== e.pid ||
            rd_flag !== e.flag) begin
          n_errors++;
          $display("FAIL %s: actual m=%0h a=%0d w=%0d c=%0d addr=%h pid=%h f=%0d expected m=%0h a=%0d w=%0d c=%0d addr=%h pid=%h f=%0d",
            e.tag, rd_master, rd_attr, rd_write, rd_ctrl, rd_addr, rd_pid, rd_flag,
            e.master, e.attr, e.wr, e.ctrl, e.addr, e.pid, e.flag);
        end
      end
    end
  end

  task automatic next();
    @(negedge clk);
    f_valid = '0;
    clr     = '0;
    rd_en   = 1'b0;
  endtask

  task automatic fault(input int p, input logic [MW-1:0] m, input logic [1:0] a,
                       input logic w, input logic [1:0] c, input logic [AW-1:0] ad,
                       input logic [PW-1:0] pd);
    f_valid[p] = 1'b1;
    f_master[p] = m; f_attr[p] = a; f_write[p] = w;
    f_ctrl[p] = c; f_addr[p] = ad; f_pid[p] = pd;
  endtask

  task automatic read(input int p, input logic [MW-1:0] m, input logic [1:0] a,
                      input logic w, input logic [1:0] c, input logic [AW-1:0] ad,
                      input logic [PW-1:0] pd, input logic f, input string tag);
    exp_t e;
    e.master = m; e.attr = a; e.wr = w; e.ctrl = c;
    e.addr = ad; e.pid = pd; e.flag = f; e.tag = tag;
    sb_q.push_back(e);
    rd_en = 1'b1;
    rd_sel = SW'(p);
    next();
  endtask

  task automatic check_flags(input logic [NP-1:0] exp, input string tag);
    n_checks++;
    if (err_flag !== exp) begin
      n_errors++;
      $display("FAIL %s: err_flag actual=%b expected=%b", tag, err_flag, exp);
    end
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      f_master[p] = '0; f_attr[p] = '0; f_ctrl[p] = '0;
      f_addr[p] = '0; f_pid[p] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_flags(5'b00000, "R1");
    read(0, 0, 0, 0, 0, 32'h0, 8'h0, 0, "R1");

    // R2 / R8: first capture on port 2, user data write, single-region
    fault(2, 4'd3, 2'd1, 1'b1, 2'd1, 32'hDEADBEE0, 8'h5A);
    next();
    check_flags(5'b00100, "R2");
    read(2, 4'd3, 2'd1, 1'b1, 2'd1, 32'hDEADBEE0, 8'h5A, 1, "R2");

    // R3: second fault on flagged port is dropped
    fault(2, 4'd9, 2'd2, 1'b0, 2'd2, 32'h12345678, 8'hC3);
    next();
    check_flags(5'b00100, "R3");
    read(2, 4'd3, 2'd1, 1'b1, 2'd1, 32'hDEADBEE0, 8'h5A, 1, "R3");

    // R4: bare clear, then clear of an idle port
    clr[2] = 1'b1;
    next();
    check_flags(5'b00000, "R4");
    clr[2] = 1'b1;
    next();
    check_flags(5'b00000, "R4");
    read(2, 4'd3, 2'd1, 1'b1, 2'd1, 32'hDEADBEE0, 8'h5A, 0, "R4");

    // R5: clear and new fault in the same cycle
    fault(4, 4'd1, 2'd0, 1'b0, 2'd0, 32'h0000_1000, 8'h11);
    next();
    clr[4] = 1'b1;
    fault(4, 4'd7, 2'd3, 1'b1, 2'd2, 32'hCAFE_0040, 8'h22);
    next();
    check_flags(5'b10000, "R5");
    read(4, 4'd7, 2'd3, 1'b1, 2'd2, 32'hCAFE_0040, 8'h22, 1, "R5");

    // R6: simultaneous faults on ports 0 and 1
    fault(0, 4'd2, 2'd2, 1'b0, 2'd1, 32'hA000_0000, 8'h01);
    fault(1, 4'd5, 2'd1, 1'b1, 2'd0, 32'hB000_0020, 8'hFE);
    next();
    check_flags(5'b10011, "R6");
    read(0, 4'd2, 2'd2, 1'b0, 2'd1, 32'hA000_0000, 8'h01, 1, "R6");
    read(1, 4'd5, 2'd1, 1'b1, 2'd0, 32'hB000_0020, 8'hFE, 1, "R6");
    clr[0] = 1'b1;
    next();
    check_flags(5'b10010, "R6");
    read(1, 4'd5, 2'd1, 1'b1, 2'd0, 32'hB000_0020, 8'hFE, 1, "R6");

    // R8: remaining encodings, supervisor instruction read, overlap; supervisor data, no hit
    fault(3, 4'd15, 2'd2, 1'b0, 2'd2, 32'hFFFF_FFE0, 8'h80);
    fault(0, 4'd0, 2'd3, 1'b0, 2'd0, 32'h0000_0020, 8'h7F);
    next();
    read(3, 4'd15, 2'd2, 1'b0, 2'd2, 32'hFFFF_FFE0, 8'h80, 1, "R8");
    read(0, 4'd0, 2'd3, 1'b0, 2'd0, 32'h0000_0020, 8'h7F, 1, "R8");

    // R7: out-of-range selects and no read without strobe
    read(5, 0, 0, 0, 0, 32'h0, 8'h0, 0, "R7");
    read(7, 0, 0, 0, 0, 32'h0, 8'h0, 0, "R7");
    next();
    n_checks++;
    if (rd_valid !== 1'b0) begin
      n_errors++;
      $display("FAIL R7: rd_valid actual=%0d expected=0", rd_valid);
    end
    n_checks++;
    if (sb_q.size() != 0) begin
      n_errors++;
      $display("FAIL R7: reads outstanding actual=%0d expected=0", sb_q.size());
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule